// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit converter that takes its data from an 8-bit bus. A 12-bit input latch is split into an 8-bit upper part and a 4-bit lower part. A second 12-bit register, the converter register, holds the code that drives the analog stage. All controls act on level and are sampled on the system clock. While a latch's enable is active, the latch reloads on every clock edge. While the enable is inactive, the latch holds its value.

The upper part of a word is written first and the lower part second, so the data is left-justified. A byte-select pin picks between a full write and a write to the lower part only. A separate transfer path, gated by write 2 and a transfer strobe, copies the latch into the converter register. This supports three ways of updating the output: automatic transfer on the second write, transfer by a later processor strobe, and transfer by an external strobe. Holding every control active gives flow-through, where the output follows the data bus.

Top module: `dbuf_dac`

## Requirements
- R1: A low `rst_n` sampled on a clock edge clears both the input latch and the converter register to zero. The cleared latch is seen through a later transfer.
- R2: A write with `cs_n`=0, `wr1_n`=0 and `byte_sel`=1 loads `din[7:0]` into latch bits 11:4 and `din[7:4]` into latch bits 3:0. `dac_code` does not change unless a transfer is active.
- R3: While `cs_n`=1, write 1 has no effect on the latch, whatever `wr1_n`, `byte_sel` and `din` are.
- R4: A write with `byte_sel`=0 loads only latch bits 3:0, from `din[7:4]`. Latch bits 11:4 keep their value, and `din[3:0]` is ignored.
- R5: On a clock edge where `wr2_n`=0 and `xfer_n`=0, the converter register takes the latch contents as they stand after that edge. `dac_code` shows the new value from that edge on.
- R6: A transfer needs both strobes. `xfer_n`=0 with `wr2_n`=1, or `wr2_n`=0 with `xfer_n`=1, leaves `dac_code` unchanged.
- R7: In automatic transfer, the second write (`byte_sel`=0) is made with the transfer active in the same cycle. `dac_code` then shows the full new word, including the new low nibble, after that single edge.
- R8: In flow-through, `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` are all 0 and `byte_sel` is 1. `dac_code` then equals {`din[7:0]`, `din[7:4]`} one edge after each value of `din`.
- R9: While write 1 is not enabled, changes on `din` do not reach the latch.
- R10: An enable held active over several edges makes the latch follow `din`. The value present at the last enabled edge is the one kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; qualifies write 1 |
| wr1_n | input | 1 | Write 1 strobe, active low; opens the input latch |
| wr2_n | input | 1 | Write 2 strobe, active low; qualifies transfer |
| xfer_n | input | 1 | Transfer strobe, active low |
| byte_sel | input | 1 | 1: full 12-bit latch write; 0: low 4 bits only |
| din | input | 8 | Data bus |
| dac_code | output | 12 | Code held by the converter register |

## Verification
A two-write sequence is checked with the transfer issued afterwards. This shows that the first byte and the low-nibble write fill the correct latch fields, and that nothing leaks to the output early. The same sequence is repeated with the transfer active during the second write, which separates automatic transfer from a delayed update. Single-strobe transfers, writes with chip select inactive, and bus activity while write 1 is idle each run with distinctive data patterns, and a later transfer exposes any disturbed latch bit. A run of flow-through values, such as C4, 0F, FF and 5A, shows that the output tracks the bus edge by edge.

// File: rtl/dbuf_dac_pkg.sv
`timescale 1ns/1ps
// Shared types for the double-buffered converter front end.
// Assumes one clock domain; every enable is active high inside the block.
package dbuf_dac_pkg;

    // Decoded enables handed from the control decoder to the storage stages
    typedef struct packed {
        logic hi_en;    // upper latch part open
        logic lo_en;    // lower latch part open
        logic xfer_en;  // converter register open
    } dac_en_t;

endpackage

// File: rtl/dbuf_ctl_decode.sv
`timescale 1ns/1ps
// Control decoder: turns the active-low pins into three active-high enables.
// Assumes the pins are already synchronous to clk.
module dbuf_ctl_decode
    import dbuf_dac_pkg::*;
(
    input  logic    cs_n,
    input  logic    wr1_n,
    input  logic    wr2_n,
    input  logic    xfer_n,
    input  logic    byte_sel,
    output dac_en_t en
);

    logic wr1_ok;

    // Qualify write 1 with chip select, then split by byte select
    always_comb begin
        wr1_ok     = !cs_n && !wr1_n;
        en.lo_en   = wr1_ok;
        en.hi_en   = wr1_ok && byte_sel;
        en.xfer_en = !wr2_n && !xfer_n;
    end

endmodule

// File: rtl/dbuf_in_latch.sv
`timescale 1ns/1ps
// Split input latch: an upper part of HI_W bits and a lower part of LO_W bits.
// Each part reloads on every edge while its enable is high (a level-sensitive
// latch modelled on the clock). lat_nxt is the value after the current edge,
// so a transfer in the same cycle sees a transparent latch.
// Assumes BUS_W == HI_W + LO_W (wide bus) or BUS_W >= HI_W (narrow bus).
module dbuf_in_latch #(
    parameter int HI_W  = 8,
    parameter int LO_W  = 4,
    parameter int BUS_W = 8,
    localparam int CODE_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic [BUS_W-1:0]  din,
    output logic [CODE_W-1:0] lat_q,
    output logic [CODE_W-1:0] lat_nxt
);

    logic [HI_W-1:0] hi_src, hi_q;
    logic [LO_W-1:0] lo_src, lo_q;

    // Pick the bus lanes that feed each part of the latch
    generate
        if (BUS_W == CODE_W) begin : g_wide
            assign hi_src = din[CODE_W-1 -: HI_W];
            assign lo_src = din[LO_W-1:0];
        end else begin : g_narrow
            logic unused_low_lanes;
            assign hi_src = din[BUS_W-1 -: HI_W];
            assign lo_src = din[BUS_W-1 -: LO_W];
            assign unused_low_lanes = ^din[BUS_W-LO_W-1:0];
        end
    endgenerate

    // Upper part storage
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_en) hi_q <= hi_src;
    end

    // Lower part storage
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_en) lo_q <= lo_src;
    end

    // Post-edge view of the latch for a same-cycle transfer
    always_comb begin
        lat_q   = {hi_q, lo_q};
        lat_nxt = {hi_en ? hi_src : hi_q, lo_en ? lo_src : lo_q};
    end

    // R4
    lo_only_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && !hi_en) |=> $stable(hi_q));

    // R10
    hi_follows_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en |=> (hi_q == $past(hi_src)));

endmodule

// File: rtl/dbuf_dac_reg.sv
`timescale 1ns/1ps
// Converter register: takes the post-edge latch value while transfer is open,
// holds otherwise. Assumes lat_nxt comes from the input latch stage.
module dbuf_dac_reg #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic [CODE_W-1:0] lat_nxt,
    output logic [CODE_W-1:0] code_q
);

    // Load or hold the converter code
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (xfer_en) code_q <= lat_nxt;
    end

    // R6
    no_xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> $stable(code_q));

    // R5
    xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> (code_q == $past(lat_nxt)));

endmodule

// File: rtl/dbuf_dac.sv
`timescale 1ns/1ps
// Top of the double-buffered converter front end: decoder, split input latch
// and converter register. Assumes all pins are synchronous to clk.
module dbuf_dac #(
    parameter int HI_W  = 8,
    parameter int LO_W  = 4,
    parameter int BUS_W = 8,
    localparam int CODE_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr1_n,
    input  logic              wr2_n,
    input  logic              xfer_n,
    input  logic              byte_sel,
    input  logic [BUS_W-1:0]  din,
    output logic [CODE_W-1:0] dac_code
);

    import dbuf_dac_pkg::*;

    dac_en_t           en;
    logic [CODE_W-1:0] lat_q;
    logic [CODE_W-1:0] lat_nxt;

    dbuf_ctl_decode u_dec (
        .cs_n     (cs_n),
        .wr1_n    (wr1_n),
        .wr2_n    (wr2_n),
        .xfer_n   (xfer_n),
        .byte_sel (byte_sel),
        .en       (en)
    );

    dbuf_in_latch #(.HI_W(HI_W), .LO_W(LO_W), .BUS_W(BUS_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_en   (en.hi_en),
        .lo_en   (en.lo_en),
        .din     (din),
        .lat_q   (lat_q),
        .lat_nxt (lat_nxt)
    );

    dbuf_dac_reg #(.CODE_W(CODE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_en (en.xfer_en),
        .lat_nxt (lat_nxt),
        .code_q  (dac_code)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && lat_q == '0));

    // R3
    cs_idle_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(lat_q));

    // R9
    wr1_idle_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_n |=> $stable(lat_q));

endmodule

// File: tb/sim_dbuf_dac.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the code expected after each edge, and
// the monitor pops and compares it shortly after that edge.
module sim_dbuf_dac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1;
    logic        byte_sel = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [11:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dbuf_dac u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
        .xfer_n(xfer_n), .byte_sel(byte_sel), .din(din), .dac_code(dac_code)
    );

    // Driver: one cycle of stimulus, with an optional expected output
    task automatic step(input logic rn, input logic cs, input logic w1,
                        input logic w2, input logic xf, input logic sel,
                        input logic [7:0] d, input bit chk,
                        input logic [11:0] exp, input string tag);
        @(negedge clk);
        rst_n = rn; cs_n = cs; wr1_n = w1; wr2_n = w2; xfer_n = xf;
        byte_sel = sel; din = d;
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    // Monitor: compare after the edge that follows each pushed item
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [11:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (dac_code !== e) begin
                    errors++;
                    $display("FAIL %s: dac_code=%h expected %h", t, dac_code, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(0, 1, 1, 1, 1, 1, 8'h00, 0, 12'h000, "R1");
        step(0, 1, 1, 1, 1, 1, 8'h00, 1, 12'h000, "R1 reset");
        // R2: first byte loads latch, output untouched
        step(1, 0, 0, 1, 1, 1, 8'hA5, 1, 12'h000, "R2 first write");
        step(1, 1, 1, 1, 1, 1, 8'h00, 1, 12'h000, "R2 idle");
        // R4: low-nibble write, din[3:0] ignored
        step(1, 0, 0, 1, 1, 0, 8'h3C, 1, 12'h000, "R4 second write");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'hA53, "R5/R4 transfer");
        // R3: write with chip select inactive
        step(1, 1, 0, 1, 1, 1, 8'hFF, 1, 12'hA53, "R3 cs idle");
        step(1, 1, 0, 1, 1, 0, 8'hEE, 1, 12'hA53, "R3 cs idle low");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'hA53, "R3 transfer");
        // R6: new first byte not visible until both strobes
        step(1, 0, 0, 1, 1, 1, 8'h12, 1, 12'hA53, "R6 load");
        step(1, 1, 1, 1, 0, 1, 8'h00, 1, 12'hA53, "R6 xfer only");
        step(1, 1, 1, 0, 1, 1, 8'h00, 1, 12'hA53, "R6 wr2 only");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'h121, "R5 both strobes");
        // R7: automatic transfer on the second write
        step(1, 0, 0, 1, 1, 1, 8'h7E, 1, 12'h121, "R7 first byte");
        step(1, 0, 0, 0, 0, 0, 8'h90, 1, 12'h7E9, "R7 auto transfer");
        // R9: bus activity while write 1 idle
        step(1, 0, 1, 1, 1, 1, 8'hFF, 1, 12'h7E9, "R9 bus FF");
        step(1, 0, 1, 1, 1, 0, 8'h55, 1, 12'h7E9, "R9 bus 55");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'h7E9, "R9 transfer");
        // R10: enable held over three edges
        step(1, 0, 0, 1, 1, 1, 8'h11, 0, 12'h000, "");
        step(1, 0, 0, 1, 1, 1, 8'h22, 0, 12'h000, "");
        step(1, 0, 0, 1, 1, 1, 8'h33, 1, 12'h7E9, "R10 held");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'h333, "R10 transfer");
        // R8: flow-through
        step(1, 0, 0, 0, 0, 1, 8'hC4, 1, 12'hC4C, "R8 C4");
        step(1, 0, 0, 0, 0, 1, 8'h0F, 1, 12'h0F0, "R8 0F");
        step(1, 0, 0, 0, 0, 1, 8'hFF, 1, 12'hFFF, "R8 FF");
        step(1, 0, 0, 0, 0, 1, 8'h5A, 1, 12'h5A5, "R8 5A");
        // R1: reset mid-run clears both registers
        step(0, 1, 1, 1, 1, 1, 8'h00, 1, 12'h000, "R1 mid reset");
        step(1, 1, 1, 0, 0, 1, 8'h00, 1, 12'h000, "R1 latch cleared");
        step(1, 1, 1, 1, 1, 1, 8'h00, 0, 12'h000, "");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule